// File: doc/BRIEF.md
# Key-Guarded Sequence Table

This block keeps a table of 16 instruction sequences, each made of four 32-bit words, for a serial-flash command sequencer. Software reaches the table through a simple word-wide register bus. The sequencer has its own read port that returns all four words of one sequence. Software reads of the table work at any time. Software writes to the table take effect only while the table is unlocked.

The lock state changes only through a two-step handshake. First a fixed magic key is written to the key register. The very next bus write must then go to the lock-control register, and it carries a lock or unlock request. A request with no key in front of it does nothing. A malformed request also does nothing. The table comes out of reset locked, with sequence 0 already holding a default read sequence. This lets a boot-time fetch work before any software runs.

Top module: `seq_table_guard`

## Requirements
- R1: After reset the table is locked. Word 0 of sequence 0 reads 0x08180403, word 1 reads 0x24001C08, and words 2 and 3 read zero. Every word of sequences 1 to 15 reads zero.
- R2: While the table is unlocked, a bus write to byte address 0x310 + 16*n + 4*w stores the data in word w of sequence n. A later bus read of that address returns the stored data.
- R3: While the table is locked, writes to the table window change no word. Bus reads still return the stored contents.
- R4: A write of 0x5AF05AF0 to the key register (0x300) arms the handshake. If the next bus write goes to the lock-control register (0x304), data bits [1:0] = 2'b10 unlock the table and 2'b01 lock it. The new state applies from the following cycle.
- R5: A lock-control write that is not directly preceded by a correct key write has no effect. Any bus write other than a correct key write disarms a pending key.
- R6: A key write with any value other than 0x5AF05AF0 does not arm the handshake.
- R7: A lock-control write with both bits [1:0] set is ignored, but it still uses up the pending key.
- R8: When seq_sel is n, seq_words carries the four words of sequence n one cycle later. Word w sits on bits [32w+31:32w].
- R9: bus_rdata updates one cycle after a read strobe. Reads of any address outside the table window return zero.
- R10: Writes to an address that is not word aligned are ignored. Writes to an address outside the table window that is neither the key nor the lock-control register are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| seq_sel | input | 4 | Sequence index for the sequencer port |
| seq_words | output | 128 | Four words of the selected sequence, registered |

## Verification
The bench sweeps all 64 table words in three situations: right after reset, after a write attempt while locked, and after a full pattern write while unlocked. It also reads all 16 sequences through the sequencer port.

The handshake tests cover these cases:
- A lock-control write with no key. A design that got this wrong would unlock on a bare command.
- A wrong key value.
- A key followed by an unrelated write. A design that kept the key armed would unlock here.
- A request with both bits set.
- A second command after a request with both bits set. A design that did not use up the key would unlock here.

The address tests cover unaligned writes and addresses just past the window. A decoder that ignored the low address bits or the upper bound would corrupt neighbouring words or alias them.

// File: rtl/seqtab_pkg.sv
// Package: shared constants for the key-guarded sequence table.
// Holds the address map, the magic key and the boot contents of sequence 0.
package seqtab_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned SEQ_COUNT = 16;
    localparam int unsigned SEQ_WORDS = 4;

    localparam logic [ADDR_W-1:0] KEY_ADDR = 12'h300;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 12'h304;
    localparam logic [ADDR_W-1:0] TBL_BASE = 12'h310;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h5AF0_5AF0;

    // Lock state of the table.
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    // Boot contents of sequence 0 (a basic read sequence); other words are zero.
    function automatic logic [31:0] boot_word(input int unsigned w);
        case (w)
            0:       return 32'h0818_0403;
            1:       return 32'h2400_1C08;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/seqtab_decode.sv
// Module: address decoder for the register bus.
// Flags the key register, the lock-control register and the table window.
// For the window it also gives the sequence and word index.
// Assumes that WORDS is a power of two and that only word-aligned addresses
// select anything.
module seqtab_decode #(
    parameter int unsigned AW       = 12,
    parameter int unsigned NUM_SEQ  = 16,
    parameter int unsigned WORDS    = 4,
    parameter logic [AW-1:0] KEY_A  = 12'h300,
    parameter logic [AW-1:0] CTL_A  = 12'h304,
    parameter logic [AW-1:0] BASE_A = 12'h310,
    localparam int unsigned SEQ_W   = $clog2(NUM_SEQ),
    localparam int unsigned WRD_W   = $clog2(WORDS)
) (
    input  logic [AW-1:0]    addr,
    output logic             hit_key,
    output logic             hit_ctl,
    output logic             hit_tbl,
    output logic [SEQ_W-1:0] seq_idx,
    output logic [WRD_W-1:0] word_idx
);
    localparam int unsigned SPAN = NUM_SEQ * WORDS * 4;

    logic [AW-1:0] off;
    logic          aligned;

    // Purpose: compute the offset into the window and the alignment flag.
    always_comb begin
        off     = addr - BASE_A;
        aligned = (addr[1:0] == 2'b00);
    end

    // Purpose: select a target and split the window offset into indices.
    always_comb begin
        hit_key  = aligned && (addr == KEY_A);
        hit_ctl  = aligned && (addr == CTL_A);
        hit_tbl  = aligned && (addr >= BASE_A) && (32'(off) < SPAN);
        word_idx = off[2 +: WRD_W];
        seq_idx  = off[2 + WRD_W +: SEQ_W];
    end
endmodule

// File: rtl/seqtab_lock.sv
// Module: key check and lock state machine.
// A correct key write arms the handshake. The next bus write uses the key up.
// If that write is a lock-control write with exactly one request bit set, it
// moves the state. Resets to locked.
// Assumes that at most one bus write arrives per cycle.
module seqtab_lock
    import seqtab_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter logic [DW-1:0] KEY_V  = 32'h5AF0_5AF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          hit_key,
    input  logic          hit_ctl,
    input  logic [DW-1:0] wdata,
    output logic          locked
);
    lock_state_e state_q;
    logic        armed_q;

    // Purpose: track the key arm flag and apply lock or unlock requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= hit_key && (wdata == KEY_V);
            if (hit_ctl && armed_q) begin
                case (wdata[1:0])
                    2'b01:   state_q <= ST_LOCKED;
                    2'b10:   state_q <= ST_OPEN;
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    assign locked = (state_q == ST_LOCKED);

    // R4: an armed unlock request opens the table.
    a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctl && armed_q && wdata[1:0] == 2'b10) |=> !locked);
    // R4: an armed lock request closes the table.
    a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctl && armed_q && wdata[1:0] == 2'b01) |=> locked);
    // R5: a control write with no key in front of it leaves the state alone.
    a_r5_no_key_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctl && !armed_q) |=> $stable(locked));
    // R7: a request with both bits set is ignored.
    a_r7_both_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctl && wdata[1:0] == 2'b11) |=> $stable(locked));
    // R5: any bus write that is not a key write leaves the handshake disarmed.
    a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_key) |=> !armed_q);
endmodule

// File: rtl/seqtab_store.sv
// Module: table storage made of flops.
// Has one write port and a combinational word read for the bus. It also has
// a registered read of a whole sequence for the sequencer.
// Sequence 0 resets to the boot contents; every other word resets to zero.
// Assumes that the write enable is already gated by the lock state.
module seqtab_store
    import seqtab_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned NUM_SEQ = 16,
    parameter int unsigned WORDS   = 4,
    localparam int unsigned SEQ_W  = $clog2(NUM_SEQ),
    localparam int unsigned WRD_W  = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEQ_W-1:0]    wr_seq,
    input  logic [WRD_W-1:0]    wr_word,
    input  logic [DW-1:0]       wdata,
    input  logic [SEQ_W-1:0]    rd_seq,
    input  logic [WRD_W-1:0]    rd_word,
    output logic [DW-1:0]       rd_data,
    input  logic [SEQ_W-1:0]    seq_sel,
    output logic [WORDS*DW-1:0] seq_words
);
    logic [NUM_SEQ-1:0][WORDS-1:0][DW-1:0] tbl;

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_row
        logic [WORDS-1:0][DW-1:0] row_q;

        // Purpose: reset one sequence row and apply writes addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) begin
                    row_q[w] <= (s == 0) ? DW'(boot_word(w)) : '0;
                end
            end else if (wr_en && (wr_seq == SEQ_W'(s))) begin
                row_q[wr_word] <= wdata;
            end
        end

        assign tbl[s] = row_q;
    end

    // Purpose: select the word for the bus read path.
    always_comb rd_data = tbl[rd_seq][rd_word];

    // Purpose: register the whole selected sequence for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_words <= '0;
        else        seq_words <= tbl[seq_sel];
    end

    // R2: the table holds its contents when no write is enabled.
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl));
endmodule

// File: rtl/seq_table_guard.sv
// Module: top of the key-guarded sequence table.
// Ties the address decoder, the lock state machine and the table storage to
// the register bus and to the sequencer read port.
// Assumes that reads and writes do not share a cycle on the same word.
// If they do, the read returns the old value.
module seq_table_guard
    import seqtab_pkg::*;
#(
    parameter int unsigned DW      = DATA_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned NUM_SEQ = SEQ_COUNT,
    parameter int unsigned WORDS   = SEQ_WORDS,
    localparam int unsigned SEQ_W  = $clog2(NUM_SEQ),
    localparam int unsigned WRD_W  = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [SEQ_W-1:0]    seq_sel,
    output logic [WORDS*DW-1:0] seq_words
);
    logic             hit_key, hit_ctl, hit_tbl, locked, tbl_we;
    logic [SEQ_W-1:0] seq_idx;
    logic [WRD_W-1:0] word_idx;
    logic [DW-1:0]    rd_word_data;

    seqtab_decode #(
        .AW(AW), .NUM_SEQ(NUM_SEQ), .WORDS(WORDS),
        .KEY_A(AW'(KEY_ADDR)), .CTL_A(AW'(CTL_ADDR)), .BASE_A(AW'(TBL_BASE))
    ) i_decode (
        .addr(bus_addr), .hit_key(hit_key), .hit_ctl(hit_ctl),
        .hit_tbl(hit_tbl), .seq_idx(seq_idx), .word_idx(word_idx)
    );

    seqtab_lock #(.DW(DW), .KEY_V(DW'(UNLOCK_KEY))) i_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .hit_key(hit_key),
        .hit_ctl(hit_ctl), .wdata(bus_wdata), .locked(locked)
    );

    // Purpose: allow a table write only inside the window while unlocked.
    always_comb tbl_we = bus_wr_en && hit_tbl && !locked;

    seqtab_store #(.DW(DW), .NUM_SEQ(NUM_SEQ), .WORDS(WORDS)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_seq(seq_idx),
        .wr_word(word_idx), .wdata(bus_wdata), .rd_seq(seq_idx),
        .rd_word(word_idx), .rd_data(rd_word_data), .seq_sel(seq_sel),
        .seq_words(seq_words)
    );

    // Purpose: register bus read data; addresses outside the window read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= hit_tbl ? rd_word_data : '0;
    end

    // R3: the storage write enable never fires while the table is locked.
    a_r3_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !tbl_we);
    // R9: a read outside the table window returns zero on the next cycle.
    a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !hit_tbl) |=> (bus_rdata == '0));
    // R9: read data holds when there is no read strobe.
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/test_seq_table_guard.sv
module test_seq_table_guard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_en = 1'b0;
    logic         bus_rd_en = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   seq_sel = '0;
    logic [127:0] seq_words;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seq_table_guard i_seq_table_guard (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_sel(seq_sel), .seq_words(seq_words)
    );

    function automatic logic [31:0] boot_exp(int n, int w);
        if (n != 0) return 32'h0;
        if (w == 0) return 32'h0818_0403;
        if (w == 1) return 32'h2400_1C08;
        return 32'h0;
    endfunction

    function automatic logic [31:0] pat(int n, int w);
        return 32'hC0DE_0000 + 32'(n * 256 + w);
    endfunction

    function automatic logic [11:0] waddr(int n, int w);
        return 12'(32'h310 + n * 16 + w * 4);
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    // Lock probe: sequence 2 word 0 stays zero if the table is still locked.
    task automatic probe_locked(string req);
        logic [31:0] d;
        wr(12'h330, 32'h1234_5678);
        rd(12'h330, d);
        check(req, 128'(d), 128'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents over the whole table
        for (int n = 0; n < 16; n++)
            for (int w = 0; w < 4; w++) begin
                rd(waddr(n, w), d);
                check("R1", 128'(d), 128'(boot_exp(n, w)));
            end
        @(negedge clk) seq_sel = 4'd0;
        @(negedge clk);
        check("R1 R8", seq_words, {96'h0, 32'h0}
              | {64'h0, 32'h2400_1C08, 32'h0818_0403});

        // R3: write attempts while locked change nothing
        for (int n = 0; n < 16; n++)
            for (int w = 0; w < 4; w++) wr(waddr(n, w), 32'hFFFF_FFFF);
        for (int n = 0; n < 16; n++)
            for (int w = 0; w < 4; w++) begin
                rd(waddr(n, w), d);
                check("R3", 128'(d), 128'(boot_exp(n, w)));
            end

        // R5: command with no key
        wr(12'h304, 32'h2);
        probe_locked("R5 bare command");
        // R6: wrong key value
        wr(12'h300, 32'h5AF0_5AF1);
        wr(12'h304, 32'h2);
        probe_locked("R6 wrong key");
        // R5: an unrelated write between key and command disarms
        wr(12'h300, 32'h5AF0_5AF0);
        wr(12'h200, 32'h0);
        wr(12'h304, 32'h2);
        probe_locked("R5 intervening write");
        // R7: both bits set is ignored and uses the key up
        wr(12'h300, 32'h5AF0_5AF0);
        wr(12'h304, 32'h3);
        probe_locked("R7 both bits");
        wr(12'h300, 32'h5AF0_5AF0);
        wr(12'h304, 32'h3);
        wr(12'h304, 32'h2);
        probe_locked("R7 key consumed");

        // R4: proper unlock, then R2 full pattern write and readback
        wr(12'h300, 32'h5AF0_5AF0);
        wr(12'h304, 32'h2);
        for (int n = 0; n < 16; n++)
            for (int w = 0; w < 4; w++) wr(waddr(n, w), pat(n, w));
        for (int n = 0; n < 16; n++)
            for (int w = 0; w < 4; w++) begin
                rd(waddr(n, w), d);
                check("R4 R2", 128'(d), 128'(pat(n, w)));
            end
        // R8: sequencer port for every sequence
        for (int n = 0; n < 16; n++) begin
            @(negedge clk) seq_sel = 4'(n);
            @(negedge clk);
            check("R8", seq_words,
                  {pat(n, 3), pat(n, 2), pat(n, 1), pat(n, 0)});
        end

        // R10: unaligned write is ignored
        wr(12'h312, 32'hDEAD_BEEF);
        rd(12'h310, d);
        check("R10 unaligned", 128'(d), 128'(pat(0, 0)));
        rd(12'h314, d);
        check("R10 unaligned neighbour", 128'(d), 128'(pat(0, 1)));
        // R10: write just past the window does not alias
        wr(12'h410, 32'hDEAD_BEEF);
        rd(12'h310, d);
        check("R10 past window", 128'(d), 128'(pat(0, 0)));
        // R9: reads outside the window return zero
        rd(12'h410, d);
        check("R9 past window", 128'(d), 128'h0);
        rd(12'h300, d);
        check("R9 key reg", 128'(d), 128'h0);
        rd(12'h30C, d);
        check("R9 below window", 128'(d), 128'h0);

        // R4: proper lock, then R3 writes ignored again
        wr(12'h300, 32'h5AF0_5AF0);
        wr(12'h304, 32'h1);
        wr(12'h310, 32'h0BAD_0BAD);
        rd(12'h310, d);
        check("R4 R3 relock", 128'(d), 128'(pat(0, 0)));
        wr(12'h40C, 32'h0BAD_0BAD);
        rd(12'h40C, d);
        check("R3 last word", 128'(d), 128'(pat(15, 3)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule